// File: doc/BRIEF.md
# Thread-Tagged Shared Set-Associative Cache

This block is the lookup and fill core of a cache that two hardware threads use at the same time. Both threads keep their lines in one array. Each line holds an owner thread number next to its address tag. A lookup hits only when the set holds a valid line whose tag and owner both match the request. The two threads therefore share capacity, but neither can ever see a line that the other one filled. Backing memory and coherence are handled elsewhere. A miss is only reported, and the surrounding logic later supplies the line through the fill port.

Lines are placed with exact least-recently-used replacement. Every set keeps one age counter per way, and that age order is shared by both threads. A fill goes to an empty way first. Only when the set is full does it evict the oldest way, whichever thread owns it. Each thread has a flush input that drops every line that thread owns.

When several operations land in one cycle, they take effect in a fixed order: flush first, then fill, then lookup. The lookup result appears on the cycle after the request.

Top module: `tt_cache`

## Requirements
- R1: A lookup presented with `lk_valid` high at a rising edge produces `rsp_valid` high after that edge, together with `rsp_hit`, `rsp_way` and `rsp_data`. On a miss, `rsp_way` and `rsp_data` are zero. When no lookup was presented, `rsp_valid` is low.
- R2: A lookup hits only on a valid line whose tag and owner thread both equal the request's. The set index is the low log2(SETS) bits of the address and the tag is the remaining upper bits. The same address looked up by the other thread misses.
- R3: One set holds WAYS (8) distinct lines at once, from either or both threads. Each line is reported on `rsp_way` with the way it was filled into, and `rsp_data` returns the data it was filled with.
- R4: A fill whose key is not yet present goes to the lowest-numbered way of its set that holds no valid line.
- R5: A fill into a full set replaces the way least recently used in that set, counted over both threads.
- R6: Every hit and every fill makes its way the most recently used in its set, so a hit protects a line from the next eviction.
- R7: A fill whose thread and address already hit in the set rewrites that same way with the new data. No duplicate entry is created.
- R8: Raising `flush_thread[t]` for one cycle invalidates every line owned by thread t. Lines of other threads are untouched.
- R9: When a lookup and a fill hit the same set in the same cycle, the fill takes effect first. The lookup sees the filled line, and the fill is aged before the lookup's hit.
- R10: A flush takes effect before a fill and before a lookup in the same cycle. A line filled in the flush cycle stays valid, and a line flushed in that cycle is already a miss for that cycle's lookup.
- R11: After reset, no line is valid, every lookup misses, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_tid | input | TID_W | Thread issuing the lookup |
| lk_addr | input | ADDR_W | Lookup address (tag and set index) |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup found a matching line |
| rsp_way | output | WAY_W | Way of the hit, zero on miss |
| rsp_data | output | DATA_W | Data of the hit, zero on miss |
| fill_valid | input | 1 | Install a line this cycle |
| fill_tid | input | TID_W | Owner thread of the new line |
| fill_addr | input | ADDR_W | Address of the new line |
| fill_data | input | DATA_W | Data of the new line |
| flush_thread | input | THREADS | One bit per thread; invalidates that thread's lines |

## Verification
A corrupted age counter does not appear at the ports right away. It shows on the next fill into a full set, which evicts the wrong way. The cycle after that, a lookup of the line that should have been evicted still hits, or a lookup of a protected line misses. A stale owner or valid bit shows on the next lookup of the affected key, one cycle later, as a hit where a miss is due or a miss where a hit is due. A wrong placement shows on that lookup as an unexpected `rsp_way`. The bench keeps its own model of tags, owners and ages and compares every lookup result against it. Long mixed runs with small tag ranges force frequent evictions, so age errors reach a port within a few fills.

// File: rtl/tt_cache_pkg.sv
package tt_cache_pkg;

  // Index of the lowest set bit; zero when the vector is empty.
  function automatic logic [5:0] lowest_one(input logic [63:0] vec);
    logic [5:0] idx;
    idx = '0;
    for (int i = 63; i >= 0; i--) begin
      if (vec[i]) idx = 6'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/tt_cache_match.sv
module tt_cache_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 6,
  parameter int TID_W = 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [WAYS-1:0]                  way_valid,
  input  logic [WAYS-1:0][TID_W-1:0]       way_tid,
  input  logic [WAYS-1:0][TAG_W-1:0]       way_tag,
  input  logic [TID_W-1:0]                 key_tid,
  input  logic [TAG_W-1:0]                 key_tag,
  output logic [WAYS-1:0]                  hit_vec,
  output logic                             hit_any,
  output logic [WAY_W-1:0]                 hit_way
);
  import tt_cache_pkg::*;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign hit_vec[g] = way_valid[g] && (way_tid[g] == key_tid) && (way_tag[g] == key_tag);
    end
  endgenerate

  assign hit_any = |hit_vec;
  assign hit_way = WAY_W'(lowest_one(64'(hit_vec)));

  AST_NO_MULTI_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R7

endmodule

// File: rtl/tt_cache_store.sv
module tt_cache_store #(
  parameter int SETS    = 4,
  parameter int WAYS    = 8,
  parameter int TAG_W   = 6,
  parameter int TID_W   = 1,
  parameter int DATA_W  = 16,
  parameter int THREADS = 2,
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [THREADS-1:0]            flush,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_set,
  input  logic [WAY_W-1:0]              wr_way,
  input  logic [TID_W-1:0]              wr_tid,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [IDX_W-1:0]              a_set,
  output logic [WAYS-1:0]               a_valid,
  output logic [WAYS-1:0][TID_W-1:0]    a_tid,
  output logic [WAYS-1:0][TAG_W-1:0]    a_tag,
  output logic [WAYS-1:0][DATA_W-1:0]   a_data,
  input  logic [IDX_W-1:0]              b_set,
  output logic [WAYS-1:0]               b_valid,
  output logic [WAYS-1:0][TID_W-1:0]    b_tid,
  output logic [WAYS-1:0][TAG_W-1:0]    b_tag
);

  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0][TID_W-1:0]  tid_q   [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][DATA_W-1:0] data_q  [SETS];
  logic [THREADS-1:0]          owned;

  // A way survives this cycle's flush unless its owner is being flushed.
  function automatic logic [WAYS-1:0] after_flush(input logic [WAYS-1:0] v,
                                                  input logic [WAYS-1:0][TID_W-1:0] t,
                                                  input logic [THREADS-1:0] f);
    logic [WAYS-1:0] r;
    for (int w = 0; w < WAYS; w++) r[w] = v[w] && !f[t[w]];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        tid_q[s]   <= '0;
        tag_q[s]   <= '0;
        data_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= after_flush(valid_q[s], tid_q[s], flush);
      end
      if (wr_en) begin
        valid_q[wr_set][wr_way] <= 1'b1;
        tid_q[wr_set][wr_way]   <= wr_tid;
        tag_q[wr_set][wr_way]   <= wr_tag;
        data_q[wr_set][wr_way]  <= wr_data;
      end
    end
  end

  // Read views already reflect this cycle's flush.
  assign a_valid = after_flush(valid_q[a_set], tid_q[a_set], flush);
  assign a_tid   = tid_q[a_set];
  assign a_tag   = tag_q[a_set];
  assign a_data  = data_q[a_set];
  assign b_valid = after_flush(valid_q[b_set], tid_q[b_set], flush);
  assign b_tid   = tid_q[b_set];
  assign b_tag   = tag_q[b_set];

  always_comb begin
    owned = '0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (valid_q[s][w]) owned[tid_q[s][w]] = 1'b1;
  end

  genvar t;
  generate
    for (t = 0; t < THREADS; t++) begin : g_flush_chk
      AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush[t] && !(wr_en && wr_tid == TID_W'(t)) |=> !owned[t]); // R8
    end
  endgenerate

endmodule

// File: rtl/tt_cache_lru.sv
module tt_cache_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 8,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int AGE_W = WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic [WAY_W-1:0] oldest_way
);

  typedef logic [WAYS-1:0][AGE_W-1:0] age_vec_t;

  age_vec_t        age_q [SETS];
  logic [WAYS-1:0] at_max;

  // Make way w the youngest; every way younger than it ages by one.
  function automatic age_vec_t touch(input age_vec_t a, input logic [WAY_W-1:0] w);
    age_vec_t r;
    r = a;
    for (int i = 0; i < WAYS; i++) begin
      if (a[i] < a[w]) r[i] = a[i] + AGE_W'(1);
    end
    r[w] = '0;
    return r;
  endfunction

  function automatic age_vec_t initial_ages();
    age_vec_t r;
    for (int i = 0; i < WAYS; i++) r[i] = AGE_W'(i);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) age_q[s] <= initial_ages();
    end else begin
      for (int s = 0; s < SETS; s++) begin
        age_vec_t nxt;
        nxt = age_q[s];
        if (fill_en && fill_set == IDX_W'(s)) nxt = touch(nxt, fill_way);
        if (hit_en && hit_set == IDX_W'(s))   nxt = touch(nxt, hit_way);
        age_q[s] <= nxt;
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      at_max[i] = (age_q[rd_set][i] == AGE_W'(WAYS - 1));
      if (at_max[i]) oldest_way = WAY_W'(i);
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(at_max) == 1); // R5

endmodule

// File: rtl/tt_cache.sv
module tt_cache #(
  parameter int THREADS = 2,
  parameter int SETS    = 4,
  parameter int WAYS    = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [TID_W-1:0]    lk_tid,
  input  logic [ADDR_W-1:0]   lk_addr,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [WAY_W-1:0]    rsp_way,
  output logic [DATA_W-1:0]   rsp_data,
  input  logic                fill_valid,
  input  logic [TID_W-1:0]    fill_tid,
  input  logic [ADDR_W-1:0]   fill_addr,
  input  logic [DATA_W-1:0]   fill_data,
  input  logic [THREADS-1:0]  flush_thread
);
  import tt_cache_pkg::*;

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic [IDX_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;

  assign lk_set = set_of(lk_addr);
  assign lk_tag = tag_of(lk_addr);
  assign fl_set = set_of(fill_addr);
  assign fl_tag = tag_of(fill_addr);

  // Store views: a = lookup set, b = fill set
  logic [WAYS-1:0]             a_valid, b_valid;
  logic [WAYS-1:0][TID_W-1:0]  a_tid, b_tid;
  logic [WAYS-1:0][TAG_W-1:0]  a_tag, b_tag;
  logic [WAYS-1:0][DATA_W-1:0] a_data;

  // Fill placement
  logic [WAYS-1:0]  fill_dup_vec;
  logic             fill_dup;
  logic [WAY_W-1:0] fill_dup_way;
  logic             free_any;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] lru_way;
  logic [WAY_W-1:0] fill_way;

  // Lookup view after same-cycle fill
  logic [WAYS-1:0]             lv_valid;
  logic [WAYS-1:0][TID_W-1:0]  lv_tid;
  logic [WAYS-1:0][TAG_W-1:0]  lv_tag;
  logic [WAYS-1:0][DATA_W-1:0] lv_data;
  logic [WAYS-1:0]             lk_hit_vec;
  logic                        lk_match;
  logic [WAY_W-1:0]            lk_hit_way;
  logic                        lk_hit;

  tt_cache_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .TID_W(TID_W),
    .DATA_W(DATA_W), .THREADS(THREADS)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_thread),
    .wr_en   (fill_valid),
    .wr_set  (fl_set),
    .wr_way  (fill_way),
    .wr_tid  (fill_tid),
    .wr_tag  (fl_tag),
    .wr_data (fill_data),
    .a_set   (lk_set),
    .a_valid (a_valid),
    .a_tid   (a_tid),
    .a_tag   (a_tag),
    .a_data  (a_data),
    .b_set   (fl_set),
    .b_valid (b_valid),
    .b_tid   (b_tid),
    .b_tag   (b_tag)
  );

  tt_cache_match #(.WAYS(WAYS), .TAG_W(TAG_W), .TID_W(TID_W)) u_fill_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .way_valid (b_valid),
    .way_tid   (b_tid),
    .way_tag   (b_tag),
    .key_tid   (fill_tid),
    .key_tag   (fl_tag),
    .hit_vec   (fill_dup_vec),
    .hit_any   (fill_dup),
    .hit_way   (fill_dup_way)
  );

  assign free_any = ~&b_valid;
  assign free_way = WAY_W'(lowest_one(64'(~b_valid)));

  tt_cache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_valid),
    .fill_set   (fl_set),
    .fill_way   (fill_way),
    .hit_en     (lk_hit),
    .hit_set    (lk_set),
    .hit_way    (lk_hit_way),
    .rd_set     (fl_set),
    .oldest_way (lru_way)
  );

  // Priority: existing key, then lowest empty way, then oldest way.
  always_comb begin
    if (fill_dup)      fill_way = fill_dup_way;
    else if (free_any) fill_way = free_way;
    else               fill_way = lru_way;
  end

  // Same-cycle fill into the lookup set is visible to the lookup.
  always_comb begin
    lv_valid = a_valid;
    lv_tid   = a_tid;
    lv_tag   = a_tag;
    lv_data  = a_data;
    if (fill_valid && fl_set == lk_set) begin
      lv_valid[fill_way] = 1'b1;
      lv_tid[fill_way]   = fill_tid;
      lv_tag[fill_way]   = fl_tag;
      lv_data[fill_way]  = fill_data;
    end
  end

  tt_cache_match #(.WAYS(WAYS), .TAG_W(TAG_W), .TID_W(TID_W)) u_lk_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .way_valid (lv_valid),
    .way_tid   (lv_tid),
    .way_tag   (lv_tag),
    .key_tid   (lk_tid),
    .key_tag   (lk_tag),
    .hit_vec   (lk_hit_vec),
    .hit_any   (lk_match),
    .hit_way   (lk_hit_way)
  );

  assign lk_hit = lk_valid && lk_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      rsp_way   <= lk_hit ? lk_hit_way : '0;
      rsp_data  <= lk_hit ? lv_data[lk_hit_way] : '0;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R1
  AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_way == '0 && rsp_data == '0); // R1
  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid); // R2
  AST_NO_EVICT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_dup && free_any |-> !b_valid[fill_way]); // R4
  AST_DUP_REUSES_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_dup |-> fill_dup_vec[fill_way]); // R7

endmodule

// File: tb/tt_cache_bench.sv
module tt_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int THREADS = 2;
  localparam int SETS    = 4;
  localparam int WAYS    = 8;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int TID_W   = 1;
  localparam int WAY_W   = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                lk_valid = 1'b0;
  logic [TID_W-1:0]    lk_tid = '0;
  logic [ADDR_W-1:0]   lk_addr = '0;
  logic                rsp_valid, rsp_hit;
  logic [WAY_W-1:0]    rsp_way;
  logic [DATA_W-1:0]   rsp_data;
  logic                fill_valid = 1'b0;
  logic [TID_W-1:0]    fill_tid = '0;
  logic [ADDR_W-1:0]   fill_addr = '0;
  logic [DATA_W-1:0]   fill_data = '0;
  logic [THREADS-1:0]  flush_thread = '0;

  int n_tests = 0;
  int n_fail  = 0;

  tt_cache #(.THREADS(THREADS), .SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .DATA_W(DATA_W))
  u_tt_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_tid(lk_tid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_data(rsp_data),
    .fill_valid(fill_valid), .fill_tid(fill_tid), .fill_addr(fill_addr), .fill_data(fill_data),
    .flush_thread(flush_thread)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: set = addr % SETS, tag = addr / SETS
  bit              m_v   [SETS][WAYS];
  int              m_t   [SETS][WAYS];
  int              m_tag [SETS][WAYS];
  logic [DATA_W-1:0] m_d [SETS][WAYS];
  int              m_age [SETS][WAYS];

  function automatic void m_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 0; m_t[s][w] = 0; m_tag[s][w] = 0; m_d[s][w] = '0; m_age[s][w] = w;
      end
  endfunction

  function automatic void m_touch(int s, int w);
    int a = m_age[s][w];
    for (int i = 0; i < WAYS; i++) if (m_age[s][i] < a) m_age[s][i]++;
    m_age[s][w] = 0;
  endfunction

  function automatic void m_flush(logic [THREADS-1:0] f);
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (m_v[s][w] && f[m_t[s][w]]) m_v[s][w] = 0;
  endfunction

  function automatic void m_fill(int t, int addr, logic [DATA_W-1:0] d);
    int s = addr % SETS;
    int g = addr / SETS;
    int w = -1;
    for (int i = 0; i < WAYS; i++)
      if (w < 0 && m_v[s][i] && m_t[s][i] == t && m_tag[s][i] == g) w = i;
    for (int i = 0; i < WAYS; i++)
      if (w < 0 && !m_v[s][i]) w = i;
    for (int i = 0; i < WAYS; i++)
      if (w < 0 && m_age[s][i] == WAYS - 1) w = i;
    m_v[s][w] = 1; m_t[s][w] = t; m_tag[s][w] = g; m_d[s][w] = d;
    m_touch(s, w);
  endfunction

  function automatic void m_look(int t, int addr, output bit h, output int w,
                                 output logic [DATA_W-1:0] d);
    int s = addr % SETS;
    int g = addr / SETS;
    h = 0; w = 0; d = '0;
    for (int i = 0; i < WAYS; i++)
      if (!h && m_v[s][i] && m_t[s][i] == t && m_tag[s][i] == g) begin
        h = 1; w = i; d = m_d[s][i];
      end
    if (h) m_touch(s, w);
  endfunction

  task automatic check(string req, bit ok, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: flush, then fill, then lookup; result checked after the edge.
  task automatic step(string req, bit lv, int lt, int la, bit fv, int ft, int fa,
                      logic [DATA_W-1:0] fd, logic [THREADS-1:0] fl);
    bit eh; int ew; logic [DATA_W-1:0] ed;
    @(negedge clk);
    lk_valid = lv; lk_tid = TID_W'(lt); lk_addr = ADDR_W'(la);
    fill_valid = fv; fill_tid = TID_W'(ft); fill_addr = ADDR_W'(fa); fill_data = fd;
    flush_thread = fl;
    m_flush(fl);
    if (fv) m_fill(ft, fa, fd);
    eh = 0; ew = 0; ed = '0;
    if (lv) m_look(lt, la, eh, ew, ed);
    @(posedge clk);
    #1;
    lk_valid = 0; fill_valid = 0; flush_thread = '0;
    if (lv)
      check(req, rsp_valid && rsp_hit == eh && int'(rsp_way) == ew && rsp_data == ed,
            {11'd0, rsp_valid, rsp_hit, rsp_way, rsp_data},
            {11'd0, 1'b1, eh, WAY_W'(ew), ed});
    else
      check(req, !rsp_valid, {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic expect_line(string req, bit h, int w);
    check(req, rsp_hit == h && int'(rsp_way) == w,
          {28'd0, rsp_hit, rsp_way}, {28'd0, h, WAY_W'(w)});
  endtask

  function automatic int ad(int tag, int set);
    return tag * SETS + set;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rng;
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset rsp_valid", !rsp_valid, {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R11: every address misses for both threads after reset
    for (int t = 0; t < THREADS; t++)
      for (int a = 0; a < (1 << ADDR_W); a++)
        step("R11 empty after reset", 1, t, a, 0, 0, 0, '0, '0);
    step("R1 idle no response", 0, 0, 0, 0, 0, 0, '0, '0);

    // R3/R4: eight lines in set 1, alternating threads; way i = thread i%2, tag i/2+1
    for (int i = 0; i < WAYS; i++)
      step("R4 fill to lowest free way", 0, 0, 0, 1, i % 2, ad(i / 2 + 1, 1), 16'(i * 37 + 5), '0);
    for (int i = 0; i < WAYS; i++) begin
      step("R3 eight lines per set", 1, i % 2, ad(i / 2 + 1, 1), 0, 0, 0, '0, '0);
      expect_line("R3 way of line", 1, i);
    end

    // R2: thread tag separates equal addresses
    step("R2 fill thread0 only", 0, 0, 0, 1, 0, ad(12, 2), 16'h1234, '0);
    step("R2 other thread misses", 1, 1, ad(12, 2), 0, 0, 0, '0, '0);
    expect_line("R2 cross-thread miss", 0, 0);
    step("R2 owner hits", 1, 0, ad(12, 2), 0, 0, 0, '0, '0);
    expect_line("R2 owner hit", 1, 0);

    // R5: way 0 is oldest; thread1 fill evicts thread0's line
    step("R5 shared lru fill", 0, 0, 0, 1, 1, ad(7, 1), 16'h0777, '0);
    step("R5 new line in way0", 1, 1, ad(7, 1), 0, 0, 0, '0, '0);
    expect_line("R5 victim way0", 1, 0);
    step("R5 evicted line gone", 1, 0, ad(1, 1), 0, 0, 0, '0, '0);
    expect_line("R5 evicted miss", 0, 0);

    // R6: hit on way1 protects it; next victim is way2
    step("R6 refresh way1", 1, 1, ad(1, 1), 0, 0, 0, '0, '0);
    step("R6 fill after refresh", 0, 0, 0, 1, 0, ad(8, 1), 16'h0888, '0);
    step("R6 victim way2", 1, 0, ad(8, 1), 0, 0, 0, '0, '0);
    expect_line("R6 victim way2", 1, 2);
    step("R6 protected line kept", 1, 1, ad(1, 1), 0, 0, 0, '0, '0);
    expect_line("R6 way1 kept", 1, 1);

    // R7: refill of a present key rewrites in place
    step("R7 refill present key", 0, 0, 0, 1, 1, ad(7, 1), 16'hBEEF, '0);
    step("R7 same way new data", 1, 1, ad(7, 1), 0, 0, 0, '0, '0);
    expect_line("R7 way0 reused", 1, 0);
    check("R7 data rewritten", rsp_data == 16'hBEEF, {16'd0, rsp_data}, 32'h0000BEEF);

    // R9: same-cycle fill and lookup of the same key
    step("R9 fill and lookup together", 1, 0, ad(10, 1), 1, 0, ad(10, 1), 16'hA10A, '0);
    check("R9 lookup sees fill", rsp_hit && rsp_data == 16'hA10A,
          {15'd0, rsp_hit, rsp_data}, {15'd0, 1'b1, 16'hA10A});

    // R8: flush thread 0
    step("R8 flush thread0", 0, 0, 0, 0, 0, 0, '0, 2'b01);
    step("R8 thread0 line gone", 1, 0, ad(8, 1), 0, 0, 0, '0, '0);
    expect_line("R8 t0 miss", 0, 0);
    step("R8 thread0 other set gone", 1, 0, ad(12, 2), 0, 0, 0, '0, '0);
    expect_line("R8 t0 set2 miss", 0, 0);
    step("R8 thread1 kept", 1, 1, ad(7, 1), 0, 0, 0, '0, '0);
    expect_line("R8 t1 hit", 1, 0);
    step("R4 fill after flush", 0, 0, 0, 1, 0, ad(20, 1), 16'h2020, '0);

    // R10: flush and fill of thread1 plus lookup in one cycle
    step("R10 flush then fill", 1, 1, ad(11, 1), 1, 1, ad(11, 1), 16'h1111, 2'b10);
    expect_line("R10 fill survives flush", 1, int'(rsp_way));
    check("R10 hit", rsp_hit == 1'b1, {31'd0, rsp_hit}, 32'd1);
    step("R10 flushed line miss", 1, 1, ad(7, 1), 0, 0, 0, '0, '0);
    expect_line("R10 old t1 miss", 0, 0);
    step("R10 flushed in same cycle", 1, 0, ad(20, 1), 0, 0, 0, '0, 2'b01);
    expect_line("R10 lookup after flush", 0, 0);

    // Mixed traffic against the model
    rng = 32'h1ACE_B00C;
    for (int n = 0; n < 4000; n++) begin
      bit lv, fv; int lt, la, ft, fa; logic [THREADS-1:0] fl;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      lv = rng[0] | rng[1];
      lt = int'(rng[2]);
      la = ad(int'(rng[7:4]) % 12, int'(rng[9:8]));
      fv = rng[10];
      ft = int'(rng[11]);
      fa = ad(int'(rng[15:12]) % 12, int'(rng[9:8] ^ {rng[3], rng[16]}));
      fl = (rng[23:17] == 7'd0) ? (rng[24] ? 2'b10 : 2'b01) : 2'b00;
      step("R5 R6 mixed traffic", lv, lt, la, fv, ft, fa, rng[31:16], fl);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule